// File: doc/BRIEF.md
# Flash Program/Erase Status Bit Generator

This block sits on the device side of a flash memory. It drives the byte returned on data reads while an embedded program or erase runs. An erase is started with a mask of the sectors to clear. A program is started with one word address and one data byte. While either operation runs, a read returns a status byte rather than array contents. Hosts use that byte to tell running work from finished work, active erase from suspended erase, and sectors chosen for erase from sectors left alone. They also use it to detect an operation that overran its pulse budget.

Two toggle bits carry complementary information. Bit 6 inverts on every completed read while an operation is actively working, whatever the address, and it freezes while erase is suspended. Bit 2 inverts only on reads that land in a sector chosen for erase, and it does this in both the active and the suspended erase. Bit 5 reports that the internal pulse counter reached its limit, which marks the operation as failed. Once it is set, only a reset command clears the failure. When no operation is active, reads come from a small behavioural array.

A read window is open while both `oe_n` and `ce_n` are low. The read completes when either strobe rises. Command inputs are one-cycle pulses that stand for the final write-enable rising edge of a command sequence.

Top module: `flash_status_gen`

## Requirements
- R1: After reset no operation runs, and every address reads 8'hFF from the array.
- R2: With no operation active, reads return array data. A program with no 0-to-1 bit finishes PROG_CYC cycles after its start edge and stores old AND new.
- R3: During an active erase, bit 6 of the status byte inverts once per completed read, at any address.
- R4: During an erase, bit 2 inverts once per completed read inside a sector whose erase_sel bit was 1 (sector = upper address bits). It holds on reads of other sectors.
- R5: In erase suspend, bit 6 holds and bit 2 keeps inverting on chosen sectors. Reads of sectors not chosen return array data.
- R6: A read window may be closed by the rise of either oe_n or ce_n. Each window counts as exactly one toggle event, however long it stays open.
- R7: Status is driven from the first cycle after the command edge that starts an operation.
- R8: A program that tries to turn a stored 0 into 1 never completes. Bit 5 reads 0 until PULSE_LIMIT cycles after the start edge and reads 1 from then on.
- R9: A failed operation keeps showing status, with bit 6 still inverting, until reset_cmd. reset_cmd then returns to array reads. reset_cmd has no effect on a running program, and new starts have no effect while failed.
- R10: A failure during a program issued in erase suspend returns, on reset_cmd, to erase suspend rather than to array reads.
- R11: An erase completes after ERASE_CYC cycles spent actively erasing, not counting suspended cycles. Chosen sectors then read 8'hFF and all other sectors are unchanged.
- R12: In the status byte, every bit other than 6, 5 and 2 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| rd_addr | input | AW | Read word address, sector in the upper bits |
| prog_go | input | 1 | Program command accepted (one cycle) |
| prog_addr | input | AW | Program word address |
| prog_data | input | 8 | Program data byte |
| erase_go | input | 1 | Sector erase command accepted (one cycle) |
| erase_sel | input | SECTORS | Sectors chosen for erase |
| suspend_cmd | input | 1 | Erase suspend command |
| resume_cmd | input | 1 | Erase resume command |
| reset_cmd | input | 1 | Reset command, clears a failure |
| dout | output | 8 | Status byte or array data |

## Verification
Reads during an erase alternate between a chosen sector and a sector that was not chosen. This separates bit 6, which follows the erase mode, from bit 2, which follows the sector. The same reads are repeated in erase suspend, which exposes the freeze of bit 6 and the switch to array data. Read windows closed by oe_n, closed by ce_n and held open for many cycles confirm that each window counts once. Programs that clear bits are run against programs that try to set cleared bits, both from idle and from erase suspend. Each is sampled one cycle before and one cycle at its completion or failure edge, so an off-by-one in either pulse counter shows up.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PROG,
        ST_ERASE,
        ST_ESUS,
        ST_ESUS_PROG,
        ST_FAIL_PROG,
        ST_FAIL_ERASE,
        ST_FAIL_ESP
    } op_state_e;

    // positions decoded by the host polling routine
    localparam int BIT_TGL1  = 6;
    localparam int BIT_LIMIT = 5;
    localparam int BIT_TGL2  = 2;

    typedef struct packed {
        logic tgl1;
        logic limit;
        logic tgl2;
    } status_bits_t;

    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // states in which the embedded algorithm is working (bit 6 moves)
    function automatic logic tgl1_runs(input op_state_e s);
        return s inside {ST_PROG, ST_ERASE, ST_ESUS_PROG,
                         ST_FAIL_PROG, ST_FAIL_ERASE, ST_FAIL_ESP};
    endfunction

    // states in which a sector erase mask is pending
    function automatic logic erase_live(input op_state_e s);
        return s inside {ST_ERASE, ST_ESUS, ST_ESUS_PROG,
                         ST_FAIL_ERASE, ST_FAIL_ESP};
    endfunction

    function automatic logic is_failed(input op_state_e s);
        return s inside {ST_FAIL_PROG, ST_FAIL_ERASE, ST_FAIL_ESP};
    endfunction

    function automatic logic [7:0] pack_status(input status_bits_t b);
        logic [7:0] v;
        v            = '0;
        v[BIT_TGL1]  = b.tgl1;
        v[BIT_LIMIT] = b.limit;
        v[BIT_TGL2]  = b.tgl2;
        return v;
    endfunction

endpackage

// File: rtl/fsg_seq.sv
module fsg_seq
    import flash_status_pkg::*;
#(
    parameter int NSEC        = 4,
    parameter int PROG_CYC    = 6,
    parameter int ERASE_CYC   = 80,
    parameter int PULSE_LIMIT = 120
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_go,
    input  logic            prog_bad,
    input  logic            erase_go,
    input  logic [NSEC-1:0] erase_sel,
    input  logic            suspend_cmd,
    input  logic            resume_cmd,
    input  logic            reset_cmd,
    output op_state_e       state,
    output logic [NSEC-1:0] erase_mask,
    output logic            prog_accept,
    output logic            prog_done,
    output logic            erase_done
);
    localparam int CW      = $clog2(PULSE_LIMIT + 1);
    localparam int ERS_END = min_int(ERASE_CYC, PULSE_LIMIT);
    localparam bit ERS_OK  = (ERASE_CYC <= PULSE_LIMIT);
    localparam bit PRG_OK  = (PROG_CYC <= PULSE_LIMIT);

    logic [CW-1:0] prg_cnt, ers_cnt;
    logic          stall_q;
    logic          prg_running, prg_end_ok, prg_end_bad, ers_end, erase_accept;
    op_state_e     nxt;

    always_comb begin
        prg_running  = (state == ST_PROG) || (state == ST_ESUS_PROG);
        prg_end_ok   = prg_running && !stall_q && PRG_OK &&
                       (prg_cnt == CW'(PROG_CYC - 1));
        prg_end_bad  = prg_running && !prg_end_ok &&
                       (prg_cnt == CW'(PULSE_LIMIT - 1));
        ers_end      = (state == ST_ERASE) && (ers_cnt == CW'(ERS_END - 1));
        erase_accept = erase_go && (|erase_sel) && (state == ST_READ);
        prog_accept  = prog_go && (((state == ST_READ) && !erase_accept) ||
                                   ((state == ST_ESUS) && !resume_cmd));
        prog_done    = prg_end_ok;
        erase_done   = ers_end && ERS_OK;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_READ: begin
                if (erase_accept)     nxt = ST_ERASE;
                else if (prog_accept) nxt = ST_PROG;
            end
            ST_PROG: begin
                if (prg_end_ok)       nxt = ST_READ;
                else if (prg_end_bad) nxt = ST_FAIL_PROG;
            end
            ST_ERASE: begin
                if (ers_end)          nxt = ERS_OK ? ST_READ : ST_FAIL_ERASE;
                else if (suspend_cmd) nxt = ST_ESUS;
            end
            ST_ESUS: begin
                if (resume_cmd)       nxt = ST_ERASE;
                else if (prog_accept) nxt = ST_ESUS_PROG;
            end
            ST_ESUS_PROG: begin
                if (prg_end_ok)       nxt = ST_ESUS;
                else if (prg_end_bad) nxt = ST_FAIL_ESP;
            end
            ST_FAIL_PROG, ST_FAIL_ERASE: begin
                if (reset_cmd)        nxt = ST_READ;
            end
            ST_FAIL_ESP: begin
                if (reset_cmd)        nxt = ST_ESUS;
            end
            default:                  nxt = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_READ;
            erase_mask <= '0;
            prg_cnt    <= '0;
            ers_cnt    <= '0;
            stall_q    <= 1'b0;
        end else begin
            state <= nxt;
            if (erase_accept)
                erase_mask <= erase_sel;
            else if (nxt == ST_READ)
                erase_mask <= '0;
            if (prog_accept) begin
                prg_cnt <= '0;
                stall_q <= prog_bad;
            end else if (prg_running) begin
                prg_cnt <= prg_cnt + 1'b1;
            end
            if (erase_accept)
                ers_cnt <= '0;
            else if (state == ST_ERASE)
                ers_cnt <= ers_cnt + 1'b1;
        end
    end

    assert_fail_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (is_failed(state) && !reset_cmd) |=> $stable(state));

    assert_susp_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ESUS) |=> $stable(ers_cnt));

    assert_cnt_cap_R8: assert property (@(posedge clk) disable iff (rst)
        prg_cnt <= CW'(PULSE_LIMIT));

    assert_mask_live_R4: assert property (@(posedge clk) disable iff (rst)
        erase_live(state) |-> (|erase_mask));

endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst,
    input  logic oe_n,
    input  logic ce_n,
    input  logic tgl1_en,
    input  logic tgl2_en,
    output logic tgl1,
    output logic tgl2
);
    logic rd_open, rd_open_q, rd_end;

    always_comb begin
        rd_open = !oe_n && !ce_n;
        rd_end  = rd_open_q && !rd_open;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_open_q <= 1'b0;
            tgl1      <= 1'b0;
            tgl2      <= 1'b0;
        end else begin
            rd_open_q <= rd_open;
            if (rd_end && tgl1_en) tgl1 <= ~tgl1;
            if (rd_end && tgl2_en) tgl2 <= ~tgl2;
        end
    end

    assert_tgl1_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        !tgl1_en |=> $stable(tgl1));

    assert_one_per_window_R6: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !ce_n) |=> $stable({tgl1, tgl2}));

endmodule

// File: rtl/fsg_array.sv
module fsg_array #(
    parameter int NSEC = 4,
    parameter int WPS  = 4,
    parameter int AW   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   rd_addr,
    input  logic [AW-1:0]   prog_addr,
    input  logic [7:0]      prog_data,
    input  logic            prog_accept,
    input  logic            prog_done,
    input  logic            erase_done,
    input  logic [NSEC-1:0] erase_mask,
    output logic [7:0]      rd_word,
    output logic            prog_bad
);
    localparam int DEPTH = NSEC * WPS;
    localparam int WW    = $clog2(WPS);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] pa_q;
    logic [7:0]    pd_q;

    always_comb begin
        rd_word  = mem[rd_addr];
        prog_bad = |(prog_data & ~mem[prog_addr]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q <= '0;
            pd_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            if (prog_accept) begin
                pa_q <= prog_addr;
                pd_q <= prog_data;
            end
            if (prog_done)
                mem[pa_q] <= mem[pa_q] & pd_q;
            if (erase_done) begin
                for (int i = 0; i < DEPTH; i++)
                    if (erase_mask[i >> WW]) mem[i] <= 8'hFF;
            end
        end
    end

    assert_done_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(prog_done && erase_done));

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int SECTORS       = 4,
    parameter int WORDS_PER_SEC = 4,
    parameter int PROG_CYC      = 6,
    parameter int ERASE_CYC     = 80,
    parameter int PULSE_LIMIT   = 120,
    localparam int SW = $clog2(SECTORS),
    localparam int AW = SW + $clog2(WORDS_PER_SEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               oe_n,
    input  logic               ce_n,
    input  logic [AW-1:0]      rd_addr,
    input  logic               prog_go,
    input  logic [AW-1:0]      prog_addr,
    input  logic [7:0]         prog_data,
    input  logic               erase_go,
    input  logic [SECTORS-1:0] erase_sel,
    input  logic               suspend_cmd,
    input  logic               resume_cmd,
    input  logic               reset_cmd,
    output logic [7:0]         dout
);
    op_state_e          state;
    logic [SECTORS-1:0] erase_mask;
    logic               prog_accept, prog_done, erase_done, prog_bad;
    logic               tgl1, tgl2, hit, show_status;
    logic [7:0]         rd_word;
    status_bits_t       sb;

    always_comb begin
        hit         = erase_mask[rd_addr[AW-1 -: SW]];
        show_status = (state != ST_READ) && !((state == ST_ESUS) && !hit);
        sb          = '{tgl1: tgl1, limit: is_failed(state), tgl2: tgl2};
        dout        = show_status ? pack_status(sb) : rd_word;
    end

    fsg_seq #(
        .NSEC(SECTORS), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .PULSE_LIMIT(PULSE_LIMIT)
    ) u_seq (
        .clk(clk), .rst(rst), .prog_go(prog_go), .prog_bad(prog_bad),
        .erase_go(erase_go), .erase_sel(erase_sel),
        .suspend_cmd(suspend_cmd), .resume_cmd(resume_cmd),
        .reset_cmd(reset_cmd), .state(state), .erase_mask(erase_mask),
        .prog_accept(prog_accept), .prog_done(prog_done),
        .erase_done(erase_done)
    );

    fsg_toggle u_tgl (
        .clk(clk), .rst(rst), .oe_n(oe_n), .ce_n(ce_n),
        .tgl1_en(tgl1_runs(state)),
        .tgl2_en(erase_live(state) && hit),
        .tgl1(tgl1), .tgl2(tgl2)
    );

    fsg_array #(
        .NSEC(SECTORS), .WPS(WORDS_PER_SEC), .AW(AW)
    ) u_arr (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .prog_addr(prog_addr),
        .prog_data(prog_data), .prog_accept(prog_accept),
        .prog_done(prog_done), .erase_done(erase_done),
        .erase_mask(erase_mask), .rd_word(rd_word), .prog_bad(prog_bad)
    );

    assert_limit_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (show_status && dout[BIT_LIMIT]) |-> is_failed(state));

    assert_susp_array_R5: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ESUS) && !hit) |-> (dout == rd_word));

endmodule

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
    localparam int PROG_CYC = 6, ERASE_CYC = 80, PULSE_LIMIT = 120;

    logic       clk = 1'b0, rst = 1'b1, oe_n = 1'b1, ce_n = 1'b1;
    logic [3:0] rd_addr = '0, prog_addr = '0;
    logic [7:0] prog_data = '0, dout;
    logic       prog_go = 0, erase_go = 0, suspend_cmd = 0, resume_cmd = 0, reset_cmd = 0;
    logic [3:0] erase_sel = '0;
    int cyc = 0, n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_status_gen #(.SECTORS(4), .WORDS_PER_SEC(4), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .PULSE_LIMIT(PULSE_LIMIT)) i_flash_status_gen (
        .clk(clk), .rst(rst), .oe_n(oe_n), .ce_n(ce_n), .rd_addr(rd_addr),
        .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_go(erase_go), .erase_sel(erase_sel), .suspend_cmd(suspend_cmd),
        .resume_cmd(resume_cmd), .reset_cmd(reset_cmd), .dout(dout));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // status byte: spare bits 7,4,3,1,0 are zero (R12)
    task automatic chk_status(input string req);
        chk(req, dout & 8'h9B, 8'h00);
    endtask

    // one read window; by_ce selects which strobe closes it; hold extra cycles
    task automatic rd(input logic [3:0] a, input bit by_ce, input int hold, output logic [7:0] v);
        @(negedge clk); rd_addr = a; oe_n = 0; ce_n = 0;
        repeat (hold) @(negedge clk);
        @(negedge clk); v = dout;
        if (by_ce) ce_n = 1; else oe_n = 1;
        @(negedge clk); oe_n = 1; ce_n = 1;
    endtask

    task automatic wait_to(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    task automatic start_prog(input logic [3:0] a, input logic [7:0] d, output int e);
        @(negedge clk); prog_addr = a; prog_data = d; prog_go = 1; e = cyc + 1;
        @(negedge clk); prog_go = 0;
    endtask

    task automatic pulse(ref logic s, output int e);
        @(negedge clk); s = 1; e = cyc + 1;
        @(negedge clk); s = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'd0, 0, 0, v);  chk("R1 addr0", v, 8'hFF);
        rd(4'd15, 1, 0, v); chk("R1 addr15", v, 8'hFF);
    endtask

    task automatic t_program();
        int s, e;
        logic [7:0] v;
        start_prog(4'd1, 8'h5A, s);
        chk_status("R7 status right after start");
        chk_status("R12 spare bits");
        e = s + PROG_CYC;
        pulse(reset_cmd, s);            // ignored while running
        wait_to(e - 1); rd_addr = 4'd1; chk_status("R9 reset ignored, still running");
        wait_to(e);     chk("R2 program done", dout, 8'h5A);
        start_prog(4'd1, 8'h52, s); wait_to(s + PROG_CYC);
        rd(4'd1, 0, 0, v); chk("R2 AND of old and new", v, 8'h52);
        start_prog(4'd4, 8'h3C, s); wait_to(s + PROG_CYC);
        rd(4'd4, 0, 0, v); chk("R2 sector1 word", v, 8'h3C);
    endtask

    task automatic t_prog_fail();
        int s, d;
        logic [7:0] a, b;
        start_prog(4'd1, 8'hFF, s);
        wait_to(s + PULSE_LIMIT - 1); rd_addr = 4'd1;
        chk("R8 limit bit low before limit", {7'b0, dout[5]}, 8'h00);
        wait_to(s + PULSE_LIMIT);
        chk("R8 limit bit set at limit", {7'b0, dout[5]}, 8'h01);
        rd(4'd1, 0, 0, a); rd(4'd1, 1, 0, b);
        chk("R9 bit6 toggles while failed", {7'b0, b[6]}, {7'b0, ~a[6]});
        erase_sel = 4'b0001; pulse(erase_go, d);
        chk("R9 start ignored while failed", {7'b0, dout[5]}, 8'h01);
        pulse(reset_cmd, d);
        rd(4'd1, 0, 0, a); chk("R9 reset returns to array", a, 8'h52);
    endtask

    task automatic t_erase();
        int s, p, r, d, e;
        logic [7:0] a, b;
        erase_sel = 4'b0010; pulse(erase_go, s);
        chk_status("R7 erase status at once");
        rd(4'd0, 0, 0, a); rd(4'd0, 0, 0, b);
        chk("R3 bit6 unselected", {7'b0, b[6]}, {7'b0, ~a[6]});
        chk("R4 bit2 holds unselected", {7'b0, b[2]}, {7'b0, a[2]});
        rd(4'd5, 0, 0, a); rd(4'd5, 1, 0, b);
        chk("R3 bit6 selected", {7'b0, b[6]}, {7'b0, ~a[6]});
        chk("R4 bit2 selected", {7'b0, b[2]}, {7'b0, ~a[2]});
        rd(4'd5, 1, 5, a);
        chk("R6 long ce window counts once", {6'b0, a[6], a[2]}, {6'b0, ~b[6], ~b[2]});
        pulse(suspend_cmd, p);
        rd(4'd5, 0, 0, a); rd(4'd5, 1, 0, b);
        chk("R5 bit6 holds in suspend", {7'b0, b[6]}, {7'b0, a[6]});
        chk("R5 bit2 toggles in suspend", {7'b0, b[2]}, {7'b0, ~a[2]});
        rd(4'd1, 0, 0, a); chk("R5 unselected reads array", a, 8'h52);
        start_prog(4'd1, 8'hFF, d);
        wait_to(d + PULSE_LIMIT - 1); rd_addr = 4'd0;
        chk("R8 no limit yet (suspend program)", {7'b0, dout[5]}, 8'h00);
        wait_to(d + PULSE_LIMIT);
        chk("R8 limit in suspend program", {7'b0, dout[5]}, 8'h01);
        pulse(resume_cmd, d);
        chk("R9 resume ignored while failed", {7'b0, dout[5]}, 8'h01);
        pulse(reset_cmd, d);
        rd(4'd1, 0, 0, a); chk("R10 back to suspend, array", a, 8'h52);
        rd(4'd6, 0, 0, a); rd(4'd6, 0, 0, b);
        chk("R10 suspend bit2 toggles", {7'b0, b[2]}, {7'b0, ~a[2]});
        chk("R10 suspend bit6 holds", {7'b0, b[6]}, {7'b0, a[6]});
        pulse(resume_cmd, r);
        e = s + ERASE_CYC + (r - p);
        wait_to(e - 1); rd_addr = 4'd4; chk_status("R11 still erasing");
        wait_to(e);     chk("R11 selected erased", dout, 8'hFF);
        rd(4'd1, 0, 0, a); chk("R11 other sector kept", a, 8'h52);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_program();
        t_prog_fail();
        t_erase();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule